// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two unsigned words one bit per clock. A strobe loads two operands into two shift registers and clears a one-bit carry memory. On every enabled step both registers move one place toward the least significant end. A single full adder combines the two bits that leave the registers with the stored carry. Its sum bit re-enters the first register at the most significant end, and its carry is kept for the next step. After exactly `W` enabled steps the first register holds the sum, and the carry memory holds the carry out of the top bit.

An internal step counter tracks the steps, so the user only has to give the start strobe. An `advance` input can stall the operation on any cycle. A one-cycle `done` pulse marks completion. The sum and the final carry stay readable until the next start.

Top module: `sadd_serial_top`

## Requirements
- R1: While reset is asserted and after it is released, `sum` is 0, `carry_out` is 0, and `done` and `busy` are 0.
- R2: On the clock edge where `start` is 1, `sum` takes `opa`, the second register takes `opb`, `carry_out` clears to 0, `busy` rises, and the step counter is set to `W`.
- R3: On each enabled step (`busy`=1, `advance`=1, `start`=0), `sum` shifts right by one place. Its new bit `W-1` is the XOR of the current `sum[0]`, the current least significant bit of the second register, and `carry_out`. The second register fills with 0.
- R4: After exactly `W` enabled steps, `sum` equals (`opa`+`opb`) mod 2^W and `carry_out` equals bit `W` of `opa`+`opb`. The all-ones plus one case gives `sum`=0 and `carry_out`=1.
- R5: `done` is 1 for exactly one cycle, namely the cycle after the final step. `busy` is 0 in that same cycle.
- R6: While `busy`=1 and `advance`=0 (with no start), `sum`, `carry_out` and the step count hold, so the operation simply takes longer.
- R7: While idle, `advance` has no effect: `sum` and `carry_out` hold until the next start.
- R8: A `start` while `busy` abandons the running addition and begins a fresh one with the new operands.
- R9: The carry memory is cleared at start, even when the previous addition ended with a carry of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load operands, clear carry, begin addition |
| advance | input | 1 | Allows one step per cycle while busy |
| opa | input | W | First operand, becomes the sum destination |
| opb | input | W | Second operand |
| sum | output | W | Contents of the first register |
| carry_out | output | 1 | Carry memory (final carry after done) |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The in-RTL assertions check on every cycle the load values, the one-place shift of both registers, the holds under stall and idle, the carry clear at start, a nonzero step count while busy, and the single-cycle `done` that follows the last step. Only the bench scenarios can show that the bits shifted in form the correct arithmetic sum after `W` steps. The same holds for the carry propagating through an all-ones operand, for random stalls leaving the result unchanged, and for an aborted addition leaving no trace in the next one. A behavioural model in the bench is compared against all outputs on every clock.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  typedef struct packed {
    logic carry;
    logic sum;
  } fa_out_t;

  function automatic fa_out_t full_add(input logic x, input logic y, input logic cin);
    fa_out_t r;
    r.sum   = x ^ y ^ cin;
    r.carry = (x & y) | (x & cin) | (y & cin);
    return r;
  endfunction
endpackage

// File: rtl/sadd_shreg.sv
module sadd_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q,
  output logic         lsb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= par_in;
    else if (shift) q <= {ser_in, q[W-1:1]};
  end

  assign lsb = q[0];

  // R3: the register moves one place per step
  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (q[W-2:0] == $past(q[W-1:1])) && (q[W-1] == $past(ser_in)));
endmodule

// File: rtl/sadd_seq.sv
module sadd_seq #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic advance,
  output logic step,
  output logic busy,
  output logic done
);
  logic [CW-1:0] left_q;
  logic          last;

  assign step = busy & advance & ~start;
  assign last = step & (left_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      left_q <= CW'(W);
      busy   <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (step) left_q <= left_q - CW'(1);
      if (last) busy <= 1'b0;
    end
  end

  p_count_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left_q != '0));
  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (done && !busy));
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_stall_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !advance && !start) |=> ($stable(left_q) && busy));
  p_start_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (left_q == CW'(W) && busy && !done));
endmodule

// File: rtl/sadd_serial_top.sv
module sadd_serial_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         advance,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         busy,
  output logic         done
);
  import sadd_pkg::*;

  logic         step;
  logic         a_lsb, b_lsb;
  logic [W-1:0] b_q;
  fa_out_t      fa;

  sadd_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
    .step(step), .busy(busy), .done(done)
  );

  assign fa = full_add(a_lsb, b_lsb, carry_out);

  sadd_shreg #(.W(W)) u_areg (
    .clk(clk), .rst_n(rst_n), .load(start), .shift(step),
    .ser_in(fa.sum), .par_in(opa), .q(sum), .lsb(a_lsb)
  );

  sadd_shreg #(.W(W)) u_breg (
    .clk(clk), .rst_n(rst_n), .load(start), .shift(step),
    .ser_in(1'b0), .par_in(opb), .q(b_q), .lsb(b_lsb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     carry_out <= 1'b0;
    else if (start) carry_out <= 1'b0;
    else if (step)  carry_out <= fa.carry;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (sum == $past(opa)) && (b_q == $past(opb)) && busy);
  p_carry_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !carry_out);
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !advance && !start) |=> ($stable(sum) && $stable(carry_out)));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sum) && $stable(carry_out)));
  p_b_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !b_q[W-1]);
endmodule

// File: tb/tb_sadd_serial_top.sv
module tb_sadd_serial_top;
  localparam int W = 8;
  localparam longint MASK = (64'd1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic advance = 1'b0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [W-1:0] sum;
  logic carry_out, busy, done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int done_seen = 0;

  longint ma, mb, mc;
  int left;
  bit mbusy, mdone;

  sadd_serial_top #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
    .opa(opa), .opb(opb), .sum(sum), .carry_out(carry_out),
    .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic tick(input bit st, input bit adv, input longint a, input longint b);
    string tag;
    start = st; advance = adv; opa = W'(a); opb = W'(b);
    @(posedge clk);
    cycles++;
    if (st) begin
      tag = "R2"; ma = a & MASK; mb = b & MASK; mc = 0; left = W; mbusy = 1; mdone = 0;
    end else if (mbusy && adv) begin
      longint s;
      tag = "R3";
      s = (ma & 1) + (mb & 1) + mc;
      ma = (ma >> 1) | ((s & 1) << (W - 1));
      mb = mb >> 1;
      mc = s >> 1;
      left--;
      mdone = (left == 0);
      if (left == 0) mbusy = 0;
    end else begin
      tag = mbusy ? "R6" : "R7";
      mdone = 0;
    end
    @(negedge clk);
    if (done) done_seen++;
    chk({tag, " sum"}, longint'(sum), ma);
    chk({tag, " carry"}, longint'(carry_out), mc);
    chk("R5 done", longint'(done), longint'(mdone));
    chk("R5 busy", longint'(busy), longint'(mbusy));
  endtask

  task automatic run_add(input longint a, input longint b, input bit stalls);
    longint full;
    int guard;
    full = (a & MASK) + (b & MASK);
    done_seen = 0;
    tick(1, 0, a, b);
    guard = 0;
    while (mbusy && guard < 200) begin
      tick(0, stalls ? (($urandom % 4) != 0) : 1'b1, 0, 0);
      guard++;
    end
    chk("R4 final sum", longint'(sum), full & MASK);
    chk("R4 final carry", longint'(carry_out), (full >> W) & 1);
    chk("R5 one done pulse", longint'(done_seen), 1);
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ma = 0; mb = 0; mc = 0; left = 0; mbusy = 0; mdone = 0;
    repeat (2) @(negedge clk);
    chk("R1 sum in reset", longint'(sum), 0);
    chk("R1 flags in reset", longint'({carry_out, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    tick(0, 1, 0, 0);
    chk("R1 after release", longint'({sum, carry_out, busy, done}), 0);

    // R4: small worked case, 4 + 7 = 11
    run_add(4, 7, 0);
    // R4: all ones plus one wraps to 0 with carry 1
    run_add(MASK, 1, 0);
    chk("R4 ones+1 carry", longint'(carry_out), 1);
    // R7: idle advance does not disturb the result
    for (int i = 0; i < 5; i++) tick(0, 1, 8'h5a, 8'ha5);
    chk("R7 idle sum held", longint'(sum), 0);
    chk("R7 idle carry held", longint'(carry_out), 1);
    // R9: carry cleared by the next start
    tick(1, 0, 1, 1);
    chk("R9 carry cleared", longint'(carry_out), 0);
    for (int i = 0; i < W; i++) tick(0, 1, 0, 0);
    chk("R9 1+1", longint'(sum), 2);
    tick(0, 0, 0, 0);
    // R6: stalls
    run_add(8'hff, 8'hff, 1);
    run_add(8'h80, 8'h80, 1);
    // R8: abort midway and restart
    tick(1, 0, 8'hff, 8'hff);
    for (int i = 0; i < 3; i++) tick(0, 1, 0, 0);
    run_add(8'h12, 8'h34, 0);
    chk("R8 restart result", longint'(sum), 64'h46);
    // random operands
    for (int i = 0; i < 30; i++) run_add($urandom & MASK, $urandom & MASK, i[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule